// File: doc/BRIEF.md
# Floating-Point Conditional Select Unit

This unit executes a single floating-point select operation against a private file of 32 double-precision registers. A 32-bit instruction word arrives with a valid strobe. When its two opcode fields match, the unit reads three source registers and tests one of them, the compare operand, against zero. It then writes one of the other two sources into the destination register. A compare operand that is zero of either sign, or positive, picks the "pass" source. A compare operand that is negative or not-a-number picks the "alternate" source. No rounding and no exception is involved, so the data moves bit for bit.

A record flag in the instruction copies four exception summary bits from an externally held floating-point status word into a 4-bit condition field. The status word is only read and is never modified. A word that fails the opcode check changes nothing and raises a one-cycle flag. A test port loads any register and reads any register back, so a bench or a bring-up routine can seed and inspect the file.

Top module: `fpsel_unit`

## Requirements
- R1: An instruction is accepted only when word bits [31:26] equal 63 and bits [5:1] equal 23.
- R2: Fields are destination [25:21], compare operand [20:16], alternate source [15:11], pass source [10:6], record flag [0].
- R3: A compare operand with sign bit 0 that is not a NaN selects the pass source. This includes positive finite values, +infinity and positive denormals.
- R4: A compare operand with sign bit 1 and nonzero magnitude that is not a NaN selects the alternate source. This includes -infinity and negative denormals.
- R5: A NaN compare operand (exponent 0x7FF, nonzero fraction) selects the alternate source, whatever its sign.
- R6: +0 and -0 both select the pass source.
- R7: The destination takes the new value at the clock edge that samples the valid instruction. Sources are read before that write, so the destination may alias any source.
- R8: With the record flag at 1, cond_out[3:0] shows status bits {FX,FEX,VX,OX} = fp_status[31:28] one cycle after the instruction, with FX in cond_out[3].
- R9: With the record flag at 0, cond_out holds its previous value.
- R10: A valid word that fails the opcode check pulses not_recog for exactly one cycle, in the cycle after it. It changes no register and leaves cond_out unchanged.
- R11: After reset, cond_out is 0, not_recog is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| fp_status | input | 32 | Floating-point status word; only bits [31:28] are read |
| tst_ld_en | input | 1 | Test load strobe |
| tst_idx | input | 5 | Test port register index |
| tst_ld_data | input | 64 | Test load data |
| tst_rd_data | output | 64 | Combinational read of register tst_idx |
| cond_out | output | 4 | Registered condition field {FX,FEX,VX,OX} |
| not_recog | output | 1 | One-cycle pulse for an unrecognised word |

## Verification
The hardest case to reach is a destination that aliases the compare operand or one of the sources. Only this case shows whether the sources are sampled before the write. Random stimulus rarely makes it happen, so directed instructions force the destination equal to each source in turn. The bench also fills the file with values whose exponents and signs are biased toward the edges: both zeros, both infinities, denormals and NaNs of either sign. A uniform random draw would almost never produce these. Unrecognised words that differ from a valid word in a single opcode bit test that the opcode match covers every bit. After each of them the bench reads back the whole register file.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned EXP_W    = 11;
  localparam int unsigned FRAC_W   = 52;
  localparam int unsigned COND_W   = 4;
  localparam logic [5:0]  PRIMARY  = 6'd63;
  localparam logic [4:0]  MINOR    = 5'd23;

  typedef struct packed {
    logic             accepted;
    logic             record;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] cmp;
    logic [IDX_W-1:0] alt;
    logic [IDX_W-1:0] pass;
  } sel_op_t;

  function automatic logic [EXP_W-1:0] fp_exp(input logic [DATA_W-1:0] v);
    return v[DATA_W-2 -: EXP_W];
  endfunction

  function automatic logic [FRAC_W-1:0] fp_frac(input logic [DATA_W-1:0] v);
    return v[FRAC_W-1:0];
  endfunction

  function automatic logic fp_is_nan(input logic [DATA_W-1:0] v);
    return (&fp_exp(v)) && (|fp_frac(v));
  endfunction

  function automatic logic fp_is_zero(input logic [DATA_W-1:0] v);
    return ~|v[DATA_W-2:0];
  endfunction

  function automatic logic fp_ge_zero(input logic [DATA_W-1:0] v);
    if (fp_is_nan(v))  return 1'b0;
    if (fp_is_zero(v)) return 1'b1;
    return ~v[DATA_W-1];
  endfunction

endpackage

// File: rtl/fpsel_decode.sv
module fpsel_decode
  import fpsel_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output sel_op_t           op
);
  logic primary_hit;
  logic minor_hit;

  assign primary_hit = (word[31:26] == PRIMARY);
  assign minor_hit   = (word[5:1]   == MINOR);

  always_comb begin
    op.accepted = primary_hit && minor_hit;
    op.record   = word[0];
    op.dst      = word[25:21];
    op.cmp      = word[20:16];
    op.alt      = word[15:11];
    op.pass     = word[10:6];
  end
endmodule

// File: rtl/fpsel_regfile.sv
module fpsel_regfile
  import fpsel_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_idx,
  input  logic [WIDTH-1:0] ld_data,
  input  logic [AW-1:0]    rd0_idx,
  input  logic [AW-1:0]    rd1_idx,
  input  logic [AW-1:0]    rd2_idx,
  input  logic [AW-1:0]    rd3_idx,
  output logic [WIDTH-1:0] rd0_data,
  output logic [WIDTH-1:0] rd1_data,
  output logic [WIDTH-1:0] rd2_data,
  output logic [WIDTH-1:0] rd3_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] wr_vec;
  logic [DEPTH-1:0] ld_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wr_vec[g] = wr_en && (wr_idx == AW'(g));
    assign ld_vec[g] = ld_en && (ld_idx == AW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)         mem[i] <= '0;
      else if (wr_vec[i]) mem[i] <= wr_data;
      else if (ld_vec[i]) mem[i] <= ld_data;
    end
  end

  assign rd0_data = mem[rd0_idx];
  assign rd1_data = mem[rd1_idx];
  assign rd2_data = mem[rd2_idx];
  assign rd3_data = mem[rd3_idx];

  AST_WR_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)) else $error("more than one entry written"); // R7

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data)) else $error("write lost"); // R7
endmodule

// File: rtl/fpsel_pick.sv
module fpsel_pick
  import fpsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic [DATA_W-1:0] alt_val,
  input  logic [DATA_W-1:0] pass_val,
  output logic [DATA_W-1:0] result,
  output logic              take_pass,
  output logic              cmp_nan,
  output logic              cmp_zero
);
  assign cmp_nan   = fp_is_nan(cmp_val);
  assign cmp_zero  = fp_is_zero(cmp_val);
  assign take_pass = fp_ge_zero(cmp_val);
  assign result    = take_pass ? pass_val : alt_val;

  AST_NAN_TAKES_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmp_nan) |-> !take_pass) else $error("NaN picked pass"); // R5

  AST_ZERO_TAKES_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmp_zero) |-> take_pass) else $error("zero picked alt"); // R6
endmodule

// File: rtl/fpsel_unit.sv
module fpsel_unit
  import fpsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic [31:0]       fp_status,
  input  logic              tst_ld_en,
  input  logic [4:0]        tst_idx,
  input  logic [63:0]       tst_ld_data,
  output logic [63:0]       tst_rd_data,
  output logic [3:0]        cond_out,
  output logic              not_recog
);
  sel_op_t           op;
  logic              do_exec;
  logic              do_record;
  logic              reject;
  logic [DATA_W-1:0] cmp_val, alt_val, pass_val, result;
  logic              take_pass, cmp_nan, cmp_zero;
  logic [COND_W-1:0] status_summary;

  fpsel_decode u_dec (.word(instr_word), .op(op));

  assign do_exec   = instr_valid && op.accepted;
  assign do_record = do_exec && op.record;
  assign reject    = instr_valid && !op.accepted;

  fpsel_regfile #(.DEPTH(32), .WIDTH(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(do_exec), .wr_idx(op.dst), .wr_data(result),
    .ld_en(tst_ld_en), .ld_idx(tst_idx), .ld_data(tst_ld_data),
    .rd0_idx(op.cmp), .rd1_idx(op.alt), .rd2_idx(op.pass), .rd3_idx(tst_idx),
    .rd0_data(cmp_val), .rd1_data(alt_val), .rd2_data(pass_val),
    .rd3_data(tst_rd_data)
  );

  fpsel_pick u_pick (
    .clk(clk), .rst_n(rst_n), .active(do_exec),
    .cmp_val(cmp_val), .alt_val(alt_val), .pass_val(pass_val),
    .result(result), .take_pass(take_pass), .cmp_nan(cmp_nan),
    .cmp_zero(cmp_zero)
  );

  // FX, FEX, VX, OX sit in the top four status bits, FX highest
  assign status_summary = fp_status[31:28];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_out  <= '0;
      not_recog <= 1'b0;
    end else begin
      not_recog <= reject;
      if (do_record) cond_out <= status_summary;
    end
  end

  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> not_recog) else $error("no reject pulse"); // R10

  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !do_exec) else $error("rejected word wrote"); // R10

  AST_COND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    do_record |=> cond_out == $past(fp_status[31:28])) else $error("cond not loaded"); // R8

  AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !do_record |=> $stable(cond_out)) else $error("cond moved"); // R9

  AST_ACCEPT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    do_exec |-> (instr_word[31:26] == 6'd63 && instr_word[5:1] == 5'd23))
    else $error("bad accept"); // R1
endmodule

// File: tb/fpsel_unit_test.sv
`timescale 1ns/1ps
module fpsel_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [31:0] fp_status = '0;
  logic        tst_ld_en = 1'b0;
  logic [4:0]  tst_idx = '0;
  logic [63:0] tst_ld_data = '0;
  logic [63:0] tst_rd_data;
  logic [3:0]  cond_out;
  logic        not_recog;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [63:0] model [32];
  logic [3:0]  model_cond = '0;

  fpsel_unit uut (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] d, input logic [4:0] a,
                                     input logic [4:0] b, input logic [4:0] c,
                                     input logic rc);
    return {6'd63, d, a, b, c, 5'd23, rc};
  endfunction

  // expected pick: alternate for NaN or any negative nonzero, else pass
  function automatic logic [63:0] expect_sel(input logic [63:0] a,
                                             input logic [63:0] b,
                                             input logic [63:0] c);
    logic nan_a, neg_a;
    nan_a = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    neg_a = a[63] && (a[62:0] != 0);
    return (nan_a || neg_a) ? b : c;
  endfunction

  task automatic load(input logic [4:0] i, input logic [63:0] v);
    @(negedge clk);
    tst_ld_en = 1'b1; tst_idx = i; tst_ld_data = v;
    @(negedge clk);
    tst_ld_en = 1'b0;
    model[i] = v;
  endtask

  function automatic logic [63:0] rd(input logic [4:0] i);
    return 64'(i);
  endfunction

  task automatic peek(input logic [4:0] i, output logic [63:0] v);
    tst_idx = i; #0.1; v = tst_rd_data;
  endtask

  task automatic run(input logic [31:0] w, input logic [31:0] st, input string req);
    logic good;
    logic [63:0] exp_v, got;
    good = (w[31:26] == 6'd63) && (w[5:1] == 5'd23);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w; fp_status = st;
    @(negedge clk);
    instr_valid = 1'b0;
    chk({req, " R10 pulse"}, {63'd0, not_recog}, {63'd0, !good});
    if (good) begin
      exp_v = expect_sel(model[w[20:16]], model[w[15:11]], model[w[10:6]]);
      model[w[25:21]] = exp_v;
      if (w[0]) model_cond = st[31:28];
      peek(w[25:21], got);
      chk({req, " R7 dst"}, got, exp_v);
      chk({req, w[0] ? " R8 cond" : " R9 cond"}, {60'd0, cond_out}, {60'd0, model_cond});
    end else begin
      chk({req, " R10 cond"}, {60'd0, cond_out}, {60'd0, model_cond});
      for (int i = 0; i < 32; i++) begin
        peek(5'(i), got);
        chk({req, " R10 regs"}, got, model[i]);
      end
    end
    @(negedge clk);
    chk({req, " R10 one cycle"}, {63'd0, not_recog}, 64'd0);
  endtask

  function automatic logic [63:0] edge_val(input int unsigned r);
    case (r % 10)
      0: return 64'h0000_0000_0000_0000;
      1: return 64'h8000_0000_0000_0000;
      2: return 64'h7FF0_0000_0000_0000;
      3: return 64'hFFF0_0000_0000_0000;
      4: return {1'b0, 11'h7FF, 52'($urandom) | 52'd1};
      5: return {1'b1, 11'h7FF, 52'($urandom) | 52'd1};
      6: return {1'b0, 11'h000, 52'($urandom) | 52'd1};
      7: return {1'b1, 11'h000, 52'($urandom) | 52'd1};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    logic [63:0] got;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 cond", {60'd0, cond_out}, 64'd0);
    chk("R11 nrec", {63'd0, not_recog}, 64'd0);
    peek(5'd17, got); chk("R11 reg", got, 64'd0);

    load(5'd2, 64'hAAAA_0000_0000_0001);  // alternate
    load(5'd3, 64'h5555_0000_0000_0002);  // pass
    load(5'd1, 64'h3FF0_0000_0000_0000); run(mk(5'd4,5'd1,5'd2,5'd3,1'b0), 32'h0, "R3 +1.0");
    load(5'd1, 64'hBFF0_0000_0000_0000); run(mk(5'd4,5'd1,5'd2,5'd3,1'b0), 32'h0, "R4 -1.0");
    load(5'd1, 64'h7FF0_0000_0000_0000); run(mk(5'd5,5'd1,5'd2,5'd3,1'b0), 32'h0, "R3 +inf");
    load(5'd1, 64'hFFF0_0000_0000_0000); run(mk(5'd5,5'd1,5'd2,5'd3,1'b0), 32'h0, "R4 -inf");
    load(5'd1, 64'h0000_0000_0000_0001); run(mk(5'd6,5'd1,5'd2,5'd3,1'b0), 32'h0, "R3 +denorm");
    load(5'd1, 64'h8000_0000_0000_0001); run(mk(5'd6,5'd1,5'd2,5'd3,1'b0), 32'h0, "R4 -denorm");
    load(5'd1, 64'h7FF8_0000_0000_0000); run(mk(5'd7,5'd1,5'd2,5'd3,1'b0), 32'h0, "R5 +NaN");
    load(5'd1, 64'hFFF0_0000_0000_0001); run(mk(5'd7,5'd1,5'd2,5'd3,1'b0), 32'h0, "R5 -NaN");
    load(5'd1, 64'h0);                   run(mk(5'd8,5'd1,5'd2,5'd3,1'b0), 32'h0, "R6 +0");
    load(5'd1, 64'h8000_0000_0000_0000); run(mk(5'd8,5'd1,5'd2,5'd3,1'b0), 32'h0, "R6 -0");
    // R2 field positions: swap alt/pass roles
    load(5'd1, 64'h4000_0000_0000_0000); run(mk(5'd9,5'd1,5'd3,5'd2,1'b0), 32'h0, "R2 swap");
    // R7 aliasing: destination equals the compare operand, then each source
    load(5'd1, 64'hC000_0000_0000_0000); run(mk(5'd1,5'd1,5'd2,5'd3,1'b0), 32'h0, "R7 dst=cmp");
    run(mk(5'd2,5'd1,5'd2,5'd3,1'b0), 32'h0, "R7 dst=alt");
    run(mk(5'd3,5'd2,5'd2,5'd3,1'b0), 32'h0, "R7 dst=pass");
    // R8 / R9
    run(mk(5'd10,5'd1,5'd2,5'd3,1'b1), 32'hA000_0000, "R8 rec");
    run(mk(5'd10,5'd1,5'd2,5'd3,1'b0), 32'h5FFF_FFFF, "R9 norec");
    run(mk(5'd10,5'd1,5'd2,5'd3,1'b1), 32'h5000_0000, "R8 rec2");
    // R1 / R10: every single opcode bit flipped
    for (int k = 0; k < 6; k++)
      run(mk(5'd11,5'd1,5'd2,5'd3,1'b1) ^ (32'h1 << (26 + k)), 32'hF000_0000, "R1 bad primary");
    for (int k = 0; k < 5; k++)
      run(mk(5'd11,5'd1,5'd2,5'd3,1'b1) ^ (32'h1 << (1 + k)), 32'hF000_0000, "R1 bad minor");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      if ($urandom_range(0, 3) == 0)
        load(5'($urandom), edge_val($urandom));
      w = mk(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
      if ($urandom_range(0, 9) == 0) w = w ^ (32'h1 << $urandom_range(26, 31));
      run(w, $urandom, "R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule